// File: doc/BRIEF.md
# Clocked Serial Byte Shifter with Selectable Bit Order

This block moves one byte at a time over a three-wire clocked serial link: a clock line, a data-out line and a data-in line. Writing the transmit byte starts a transfer. The shift clock either comes from an internal divider (master) or from the far end (slave, through a two-flop synchronizer). Each transfer shifts out the loaded byte and, in the same eight clock periods, assembles a received byte that is readable once the transfer ends.

Two configuration inputs pick the bit order, least significant bit first or most significant bit first, and pick between full-duplex operation and a receive-only mode. In receive-only mode the data-out line stays at its idle high level and incoming bits are still captured. A one-cycle completion pulse marks the end of every byte. A write that arrives while a transfer is running is dropped and raises an overrun flag.

Top module: `sio_shift_port`

## Requirements
- R1: After reset, sck_out and so are 1, busy, done_irq and overrun are 0, and rd_data is 0.
- R2: A wr_en pulse while busy is 0 loads wr_data and sets busy in the next cycle.
- R3: The shift clock idles high. In master mode each transfer makes exactly 8 low-then-high periods on sck_out and then stops high.
- R4: With cfg_lsb_first=1, bit 0 of the byte is sent first and the first received bit lands in rd_data bit 0. With cfg_lsb_first=0, bit 7 goes first in both directions.
- R5: si is sampled on each rising shift-clock edge, and after completion rd_data holds the 8 sampled bits.
- R6: so changes only at falling shift-clock edges during a transfer. It presents the next transmit bit and is 1 whenever no transfer runs.
- R7: With cfg_rx_only=1, so stays 1 for the whole transfer and rd_data still receives all 8 bits.
- R8: With cfg_master=0, sck_oe is 0 and transfers are clocked by edges of sck_in.
- R9: done_irq is a single-cycle pulse in the cycle where busy falls after the 8th rising edge.
- R10: A wr_en while busy is 1 leaves the running transfer unchanged and sets overrun. The next accepted write clears overrun.
- R11: In master mode each shift-clock half period lasts cfg_div+1 clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: drive the shift clock from the divider; 0: follow sck_in |
| cfg_lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| cfg_rx_only | input | 1 | 1: receive only, so held high |
| cfg_div | input | DIV_W | Master half period minus one, in clk cycles |
| wr_en | input | 1 | Load the transmit byte and start a transfer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle transfer-complete pulse |
| overrun | output | 1 | A write arrived during a transfer |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sck_oe | output | 1 | Shift-clock output enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |

## Verification
The hardest case to reach is a buffer write that lands in the middle of a master transfer. It must leave the byte on so and the captured byte untouched, and it still has to raise the flag. The bench follows the generated clock edge by edge and injects the stray write between a falling edge and the next rising edge. It then compares the full serial stream and rd_data with the original byte. The transfer after that one checks that the flag is cleared again.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Single-cycle shift-clock edge events seen by the shifter.
  typedef struct packed {
    logic fall;
    logic rise;
  } sio_edges_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck_q,
  output sio_edges_t       ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit;

  assign hit     = run && (cnt_q == div);
  assign ev.fall = hit && sck_q;
  assign ev.rise = hit && !sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (hit) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge
  import sio_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_in,
  input  logic       si_in,
  output logic       si_s,
  output sio_edges_t ev
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] si_pipe;
  logic              sck_d;
  logic              sck_s;

  assign sck_s   = sck_pipe[STAGES-1];
  assign si_s    = si_pipe[STAGES-1];
  assign ev.fall = sck_d && !sck_s;
  assign ev.rise = !sck_d && sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '1;
      si_pipe  <= '0;
      sck_d    <= 1'b1;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
      si_pipe  <= {si_pipe[STAGES-2:0], si_in};
      sck_d    <= sck_s;
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              lsb_first,
  input  logic              rx_only,
  input  sio_edges_t        ev,
  input  logic              si_bit,
  output logic              busy,
  output logic              done,
  output logic              so,
  output logic [DATA_W-1:0] rx_data
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  // Bit presented on the line for the current shift position.
  function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  // Register after one shift, with the sampled bit entering at the far end.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic lsb, input logic b);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_next;

  assign sr_next = shift_in(sr_q, lsb_first, si_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      so      <= 1'b1;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sr_q  <= tx_data;
        cnt_q <= '0;
        busy  <= 1'b1;
        so    <= 1'b1;
      end else if (busy) begin
        if (ev.fall) begin
          so <= rx_only ? 1'b1 : out_bit(sr_q, lsb_first);
        end
        if (ev.rise) begin
          sr_q  <= sr_next;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            so      <= 1'b1;
            rx_data <= sr_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_lsb_first,
  input  logic              cfg_rx_only,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done_irq,
  output logic              overrun,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              si,
  output logic              so
);
  sio_edges_t ev_master;
  sio_edges_t ev_slave;
  sio_edges_t ev_sel;
  logic       si_sync;
  logic       si_sel;
  logic       start_evt;
  logic       stray_wr_evt;
  logic       edge_fall;
  logic       edge_rise;

  assign start_evt    = wr_en && !busy;
  assign stray_wr_evt = wr_en && busy;
  assign ev_sel       = cfg_master ? ev_master : ev_slave;
  assign si_sel       = cfg_master ? si : si_sync;
  assign edge_fall    = ev_sel.fall;
  assign edge_rise    = ev_sel.rise;
  assign sck_oe       = cfg_master;

  sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy && cfg_master),
    .div   (cfg_div),
    .sck_q (sck_out),
    .ev    (ev_master)
  );

  sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_in (sck_in),
    .si_in  (si),
    .si_s   (si_sync),
    .ev     (ev_slave)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .tx_data   (wr_data),
    .lsb_first (cfg_lsb_first),
    .rx_only   (cfg_rx_only),
    .ev        (ev_sel),
    .si_bit    (si_sel),
    .busy      (busy),
    .done      (done_irq),
    .so        (so),
    .rx_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            overrun <= 1'b0;
    else if (start_evt)    overrun <= 1'b0;
    else if (stray_wr_evt) overrun <= 1'b1;
  end
endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rx_only,
  input logic wr_en,
  input logic busy,
  input logic done_irq,
  input logic overrun,
  input logic so,
  input logic sck_out,
  input logic edge_fall
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);

  a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  a_r6_so_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> so);

  a_r6_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (so != $past(so))) |-> $past(edge_fall));

  a_r7_rx_only_so_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_rx_only) |-> so);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> overrun);
endmodule

bind sio_shift_port sio_shift_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rx_only (cfg_rx_only),
  .wr_en       (wr_en),
  .busy        (busy),
  .done_irq    (done_irq),
  .overrun     (overrun),
  .so          (so),
  .sck_out     (sck_out),
  .edge_fall   (edge_fall)
);

// File: tb/sio_shift_port_tb_top.sv
module sio_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SLV   = 8;
  localparam int NVEC       = 6;
  // {master, lsb_first, rx_only, div[3:0], tx[7:0], rx[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 4'd1, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b0, 4'd2, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b1, 4'd0, 8'h5A, 8'hC3},
    {1'b0, 1'b1, 1'b0, 4'd0, 8'h81, 8'h7E},
    {1'b0, 1'b0, 1'b1, 4'd0, 8'h0F, 8'hF0},
    {1'b1, 1'b1, 1'b1, 4'd3, 8'hFF, 8'h01}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1, cfg_lsb_first = 1'b1, cfg_rx_only = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy, done_irq, overrun;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe;
  logic       si = 1'b0;
  logic       so;

  int n_chk = 0;
  int n_fail = 0;
  int rise_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge sck_out) rise_cnt++;

  sio_shift_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
    .cfg_rx_only(cfg_rx_only), .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done_irq(done_irq), .overrun(overrun),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_xfer(input logic m, input logic lsb, input logic rxo,
                          input logic [3:0] dv, input logic [7:0] tx,
                          input logic [7:0] rx, input bit poke);
    logic [7:0] so_byte;
    int         base;
    time        t_fall0, t_fall1;
    bit         seen;
    so_byte = 8'h00;
    t_fall0 = 0;
    t_fall1 = 0;
    seen    = 1'b0;
    tick();
    cfg_master = m; cfg_lsb_first = lsb; cfg_rx_only = rxo; cfg_div = {4'b0, dv};
    wr_data = tx; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    base = rise_cnt;
    check(busy == 1'b1, "R2", "busy after write", busy, 1);
    check(overrun == 1'b0, "R10", "overrun clear after accepted write", overrun, 0);
    for (int i = 0; i < 8; i++) begin
      if (m) begin
        @(negedge sck_out);
        if (i == 0) t_fall0 = $time;
        if (i == 1) t_fall1 = $time;
        #1;
      end else begin
        sck_in = 1'b0;
      end
      si = lsb ? rx[i] : rx[7-i];
      if (!m) repeat (HALF_SLV) tick();
      if (lsb) so_byte[i] = so; else so_byte[7-i] = so;
      if (poke && i == 2) begin
        tick();
        wr_en = 1'b1; wr_data = 8'h00;
        tick();
        wr_en = 1'b0;
        check(overrun == 1'b1, "R10", "overrun after stray write", overrun, 1);
        check(busy == 1'b1, "R10", "stray write keeps transfer running", busy, 1);
      end
      if (!m) begin
        sck_in = 1'b1;
        if (i != 7) repeat (HALF_SLV) tick();
      end
    end
    for (int k = 0; k < 60 && !seen; k++) begin
      if (done_irq) seen = 1'b1;
      else tick();
    end
    check(seen, "R9", "done pulse seen", seen, 1);
    check(busy == 1'b0, "R9", "busy low with done", busy, 0);
    check(rd_data == rx, "R5", "received byte (R4 order)", rd_data, rx);
    if (rxo) check(so_byte == 8'hFF, "R7", "so held high in receive-only", so_byte, 8'hFF);
    else     check(so_byte == tx, "R4", "transmitted stream (R6)", so_byte, tx);
    tick();
    check(done_irq == 1'b0, "R9", "done lasts one cycle", done_irq, 0);
    repeat (12) tick();
    check(so == 1'b1, "R6", "so idle high", so, 1);
    if (m) begin
      check(rise_cnt - base == 8, "R3", "sck periods per transfer", rise_cnt - base, 8);
      check(sck_out == 1'b1, "R3", "sck stops high", sck_out, 1);
      check(t_fall1 - t_fall0 == 2 * (dv + 1) * CLK_PERIOD, "R11", "sck period",
            int'(t_fall1 - t_fall0), 2 * (dv + 1) * CLK_PERIOD);
      check(sck_oe == 1'b1, "R8", "sck_oe in master", sck_oe, 1);
    end else begin
      check(sck_oe == 1'b0, "R8", "sck_oe in slave", sck_oe, 0);
      check(rise_cnt == base, "R8", "no generated sck in slave", rise_cnt - base, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sck_out == 1'b1 && so == 1'b1, "R1", "lines high in reset", {sck_out, so}, 3);
    rst_n = 1'b1;
    tick();
    check(busy == 1'b0 && done_irq == 1'b0 && overrun == 1'b0, "R1", "flags low",
          {busy, done_irq, overrun}, 0);
    check(rd_data == 8'h00, "R1", "rd_data after reset", rd_data, 0);
    for (int v = 0; v < NVEC; v++) begin
      run_xfer(VEC[v][22], VEC[v][21], VEC[v][20], VEC[v][19:16],
               VEC[v][15:8], VEC[v][7:0], 1'b0);
    end
    // Stray write during a master transfer, then a clean transfer clears the flag.
    run_xfer(1'b1, 1'b1, 1'b0, 4'd3, 8'h96, 8'h69, 1'b1);
    check(overrun == 1'b1, "R10", "overrun held after transfer", overrun, 1);
    run_xfer(1'b1, 1'b0, 1'b0, 4'd1, 8'h3E, 8'hD2, 1'b0);
    finish_run();
  end
endmodule